// File: doc/BRIEF.md
# SMBus Voltage-ID Register Slave

This block is a bit-level SMBus target that keeps two voltage-ID divider codes for a pair of DC/DC converters. It runs on a fast system clock and oversamples the SCL and SDA wires. It finds start, repeated-start and stop conditions on its own. It shifts in address, command and data bytes, returns ACK bits, and pulls SDA low through an active-low output enable. It never drives SDA high.

A host loads both codes with one Write Word transaction that carries the setup command. It reads them back with a Read Word transaction. Each returned byte holds the code, the converter status and zero padding. Write Word transactions that carry any other command are acknowledged, but their data is discarded. While the converters are running, setup writes are refused. A select input picks which stored code drives the divider output. A flag reports that both codes have been loaded at least once since reset.

Top module: `smb_vid_slave`

## Requirements
- R1: While `rst` is high, and on the first cycle after it drops, `vid_o` is 0, `setup_done_o` is 0 and `sda_oe_o` is 0.
- R2: The slave ACKs an address byte only when bits 7:1 equal `DEV_ADDR`. For any other address it never pulls SDA low during that transaction.
- R3: A Write Word runs in this order: address with bit 0 = 0, command `SETUP_CMD`, low byte, high byte. All four bytes are ACKed. Bits 7:3 of the low byte go to code 0 and bits 7:3 of the high byte go to code 1. Both codes are written together once the eighth bit of the high byte has been sampled.
- R4: A Read Word runs in this order: write address, command byte, repeated start, address with bit 0 = 1. The slave then sends the byte for code 0, then the byte for code 1, most significant bit first.
- R5: Each returned byte is {code[4:0], status, 2'b00}. The status bit is 0 when `run_status_i` is high and 1 when it is low.
- R6: If the master does not acknowledge a returned byte, the slave stops driving SDA and waits for the next start. This happens after the high byte, and also after the low byte when the master NACKs it.
- R7: A Write Word whose command is not `SETUP_CMD` is acknowledged but leaves both codes unchanged.
- R8: While `run_status_i` and `ext_en_i` are both high, a setup transaction changes neither code and does not set `setup_done_o`.
- R9: One cycle after a change, `vid_o` shows code 1 when `sel_i` is high and code 0 when `sel_i` is low.
- R10: `setup_done_o` rises after the first accepted setup transaction and then stays high until reset.
- R11: A start or stop condition in any state aborts the transfer. A setup transaction cut short before its high byte is complete writes nothing.
- R12: `sda_oe_o` is high only during the slave's ACK bits and during read data bits that are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | SMBus clock wire (asynchronous) |
| sda_i | input | 1 | SMBus data wire as seen on the bus (asynchronous) |
| sda_oe_o | output | 1 | High pulls SDA low |
| sel_i | input | 1 | Chooses code 1 (high) or code 0 (low) for `vid_o` |
| run_status_i | input | 1 | Converter enable from the on/off control; sets the read-back status bit |
| ext_en_i | input | 1 | External converter enable; together with `run_status_i` locks writes |
| vid_o | output | VID_W | Active divider code, registered |
| setup_done_o | output | 1 | Both codes have been loaded since reset |

## Verification
The bench builds the block with its default parameters: 5-bit codes, a two-stage synchronizer, target address 0x2A and setup command 0x5C. With 7-bit addresses and 5-bit codes, every address can be offered, and every code value can be written, selected and read back along with its status bit, all in a short run. Against that sweep the bench adds the following cases: a non-setup command, writes while locked and unlocked, transfers aborted by a stop or a repeated start, and a master NACK on the low byte.

// File: rtl/smb_vid_pkg.sv
package smb_vid_pkg;
  // Bit-level link states.
  typedef enum logic [2:0] {
    S_IDLE,
    S_RX,
    S_ACK_WAIT,
    S_ACK,
    S_TX,
    S_MACK
  } link_st_e;

  // Which byte of a write transfer is being received.
  typedef enum logic [1:0] {
    K_ADDR,
    K_CMD,
    K_DLO,
    K_DHI
  } rx_kind_e;
endpackage

// File: rtl/smb_line_sync.sv
module smb_line_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det,
  output logic sda_bit
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0] scl_sh, sda_sh;
  logic scl_d, sda_d;
  logic scl_s, sda_s;

  assign scl_s = scl_sh[LAST];
  assign sda_s = sda_sh[LAST];

  // Idle bus reads high on both wires.
  always_ff @(posedge clk) begin
    if (rst) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[LAST-1:0], scl_i};
      sda_sh <= {sda_sh[LAST-1:0], sda_i};
      scl_d  <= scl_s;
      sda_d  <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_d;
  assign scl_fall  = ~scl_s & scl_d;
  assign start_det = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;
  assign sda_bit   = sda_s;
endmodule

// File: rtl/smb_vid_link.sv
module smb_vid_link
  import smb_vid_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR  = 7'h2A,
  parameter logic [7:0] SETUP_CMD = 8'h5C,
  parameter int         VID_W     = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             start_det,
  input  logic             stop_det,
  input  logic             sda_bit,
  input  logic [7:0]       rd_byte0,
  input  logic [7:0]       rd_byte1,
  output logic             sda_oe_o,
  output logic             commit_o,
  output logic [VID_W-1:0] code_lo_o,
  output logic [VID_W-1:0] code_hi_o
);
  link_st_e   st_q;
  rx_kind_e   kind_q;
  logic [3:0] cnt_q;
  logic [7:0] sh_q;
  logic       oe_q, commit_q, rd_q, setup_q, tx_hi_q, mack_q;
  logic [VID_W-1:0] lo_q, hi_q;
  logic [7:0] byte_w;

  assign byte_w = {sh_q[6:0], sda_bit};

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= S_IDLE;
      kind_q   <= K_ADDR;
      cnt_q    <= '0;
      sh_q     <= '0;
      oe_q     <= 1'b0;
      commit_q <= 1'b0;
      rd_q     <= 1'b0;
      setup_q  <= 1'b0;
      tx_hi_q  <= 1'b0;
      mack_q   <= 1'b0;
      lo_q     <= '0;
      hi_q     <= '0;
    end else begin
      commit_q <= 1'b0;
      if (start_det) begin
        st_q    <= S_RX;
        kind_q  <= K_ADDR;
        cnt_q   <= '0;
        oe_q    <= 1'b0;
        setup_q <= 1'b0;
      end else if (stop_det) begin
        st_q <= S_IDLE;
        oe_q <= 1'b0;
      end else begin
        case (st_q)
          S_RX: if (scl_rise) begin
            sh_q  <= byte_w;
            cnt_q <= cnt_q + 4'd1;
            if (cnt_q == 4'd7) begin
              st_q <= S_ACK_WAIT;
              case (kind_q)
                K_ADDR: begin
                  rd_q <= byte_w[0];
                  if (byte_w[7:1] != DEV_ADDR) st_q <= S_IDLE;
                end
                K_CMD: setup_q <= (byte_w == SETUP_CMD);
                K_DLO: lo_q <= byte_w[7 -: VID_W];
                default: begin
                  hi_q     <= byte_w[7 -: VID_W];
                  commit_q <= setup_q;
                end
              endcase
            end
          end
          S_ACK_WAIT: if (scl_fall) begin
            oe_q <= 1'b1;
            st_q <= S_ACK;
          end
          S_ACK: if (scl_fall) begin
            cnt_q <= '0;
            if (kind_q == K_ADDR && rd_q) begin
              st_q    <= S_TX;
              tx_hi_q <= 1'b0;
              sh_q    <= rd_byte0;
              oe_q    <= ~rd_byte0[7];
            end else begin
              oe_q <= 1'b0;
              case (kind_q)
                K_ADDR: begin kind_q <= K_CMD; st_q <= S_RX; end
                K_CMD:  begin kind_q <= K_DLO; st_q <= S_RX; end
                K_DLO:  begin kind_q <= K_DHI; st_q <= S_RX; end
                default: st_q <= S_IDLE;
              endcase
            end
          end
          S_TX: begin
            if (scl_rise) cnt_q <= cnt_q + 4'd1;
            if (scl_fall) begin
              if (cnt_q == 4'd8) begin
                oe_q <= 1'b0;
                st_q <= S_MACK;
              end else begin
                sh_q <= {sh_q[6:0], 1'b0};
                oe_q <= ~sh_q[6];
              end
            end
          end
          S_MACK: begin
            if (scl_rise) mack_q <= ~sda_bit;
            if (scl_fall) begin
              if (mack_q && !tx_hi_q) begin
                st_q    <= S_TX;
                tx_hi_q <= 1'b1;
                cnt_q   <= '0;
                sh_q    <= rd_byte1;
                oe_q    <= ~rd_byte1[7];
              end else begin
                st_q <= S_IDLE;
              end
            end
          end
          default: st_q <= S_IDLE;
        endcase
      end
    end
  end

  assign sda_oe_o  = oe_q;
  assign commit_o  = commit_q;
  assign code_lo_o = lo_q;
  assign code_hi_o = hi_q;

  AST_OE_ONLY_ACK_TX: assert property (@(posedge clk) disable iff (rst) oe_q |-> (st_q == S_ACK || st_q == S_TX)); // R12
  AST_START_RESTARTS: assert property (@(posedge clk) disable iff (rst) start_det |=> (st_q == S_RX && kind_q == K_ADDR)); // R11
  AST_STOP_IDLES: assert property (@(posedge clk) disable iff (rst) stop_det |=> (st_q == S_IDLE && !oe_q)); // R11
endmodule

// File: rtl/smb_vid_regs.sv
module smb_vid_regs #(
  parameter int VID_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             commit_i,
  input  logic [VID_W-1:0] code_lo_i,
  input  logic [VID_W-1:0] code_hi_i,
  input  logic             run_status_i,
  input  logic             ext_en_i,
  input  logic             sel_i,
  output logic [VID_W-1:0] vid_o,
  output logic             setup_done_o,
  output logic [7:0]       rd_byte0_o,
  output logic [7:0]       rd_byte1_o
);
  localparam int PAD_W = 8 - VID_W - 1;

  logic [VID_W-1:0] reg0_q, reg1_q, vid_q;
  logic             done_q;
  logic             lock_w;

  assign lock_w = run_status_i & ext_en_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      reg0_q <= '0;
      reg1_q <= '0;
      done_q <= 1'b0;
      vid_q  <= '0;
    end else begin
      if (commit_i && !lock_w) begin
        reg0_q <= code_lo_i;
        reg1_q <= code_hi_i;
        done_q <= 1'b1;
      end
      vid_q <= sel_i ? reg1_q : reg0_q;
    end
  end

  // Status bit is low while the converters run; padding bits read as zero.
  assign rd_byte0_o   = 8'({reg0_q, ~run_status_i}) << PAD_W;
  assign rd_byte1_o   = 8'({reg1_q, ~run_status_i}) << PAD_W;
  assign vid_o        = vid_q;
  assign setup_done_o = done_q;

  AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (rst) lock_w |=> ($stable(reg0_q) && $stable(reg1_q))); // R8
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst) done_q |=> done_q); // R10
endmodule

// File: rtl/smb_vid_slave.sv
module smb_vid_slave #(
  parameter logic [6:0] DEV_ADDR    = 7'h2A,
  parameter logic [7:0] SETUP_CMD   = 8'h5C,
  parameter int         VID_W       = 5,
  parameter int         SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_oe_o,
  input  logic             sel_i,
  input  logic             run_status_i,
  input  logic             ext_en_i,
  output logic [VID_W-1:0] vid_o,
  output logic             setup_done_o
);
  logic scl_rise, scl_fall, start_det, stop_det, sda_bit;
  logic commit;
  logic [VID_W-1:0] code_lo, code_hi;
  logic [7:0] rd_byte0, rd_byte1;

  smb_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det), .sda_bit(sda_bit)
  );

  smb_vid_link #(.DEV_ADDR(DEV_ADDR), .SETUP_CMD(SETUP_CMD), .VID_W(VID_W)) u_link (
    .clk(clk), .rst(rst), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det), .sda_bit(sda_bit),
    .rd_byte0(rd_byte0), .rd_byte1(rd_byte1),
    .sda_oe_o(sda_oe_o), .commit_o(commit),
    .code_lo_o(code_lo), .code_hi_o(code_hi)
  );

  smb_vid_regs #(.VID_W(VID_W)) u_regs (
    .clk(clk), .rst(rst), .commit_i(commit),
    .code_lo_i(code_lo), .code_hi_i(code_hi),
    .run_status_i(run_status_i), .ext_en_i(ext_en_i), .sel_i(sel_i),
    .vid_o(vid_o), .setup_done_o(setup_done_o),
    .rd_byte0_o(rd_byte0), .rd_byte1_o(rd_byte1)
  );
endmodule

// File: tb/smb_vid_slave_bench.sv
module smb_vid_slave_bench;
  localparam logic [6:0] DEV   = 7'h2A;
  localparam logic [7:0] SETUP = 8'h5C;
  localparam logic [7:0] ONCMD = 8'h3A;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst, scl_m, sda_m, sel, run, ext;
  logic sda_oe, sda_line, done;
  logic [4:0] vid;
  int checks = 0;
  int fails  = 0;

  assign sda_line = sda_m & ~sda_oe;

  smb_vid_slave u_smb_vid_slave (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line), .sda_oe_o(sda_oe),
    .sel_i(sel), .run_status_i(run), .ext_en_i(ext),
    .vid_o(vid), .setup_done_o(done)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(4); scl_m = 1'b1; tick(8);
    sda_m = 1'b0; tick(8); scl_m = 1'b0; tick(4);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(4); scl_m = 1'b1; tick(8); sda_m = 1'b1; tick(8);
  endtask

  task automatic put_bit(input logic b);
    sda_m = b; tick(4); scl_m = 1'b1; tick(8); scl_m = 1'b0; tick(4);
  endtask

  task automatic get_bit(output logic b);
    sda_m = 1'b1; tick(4); scl_m = 1'b1; tick(4); b = sda_line;
    tick(4); scl_m = 1'b0; tick(4);
  endtask

  task automatic send_byte(input logic [7:0] v, output logic ack);
    logic x;
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(x);
    ack = ~x;
  endtask

  task automatic recv_byte(output logic [7:0] v, input logic ack);
    for (int i = 7; i >= 0; i--) get_bit(v[i]);
    put_bit(~ack);
  endtask

  task automatic write_word(input logic [7:0] c, input logic [7:0] lo, input logic [7:0] hi,
                            output logic [3:0] acks);
    bus_start();
    send_byte({DEV, 1'b0}, acks[3]);
    send_byte(c, acks[2]);
    send_byte(lo, acks[1]);
    send_byte(hi, acks[0]);
    bus_stop();
  endtask

  task automatic read_word(input logic ack_lo, output logic [7:0] lo, output logic [7:0] hi,
                           output logic [2:0] acks);
    bus_start();
    send_byte({DEV, 1'b0}, acks[2]);
    send_byte(ONCMD, acks[1]);
    bus_start();
    send_byte({DEV, 1'b1}, acks[0]);
    recv_byte(lo, ack_lo);
    recv_byte(hi, 1'b0);
    bus_stop();
  endtask

  function automatic logic [7:0] exp_byte(input logic [4:0] v, input logic r);
    return 8'(v * 8 + (r ? 0 : 4));
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic       a;
    logic [3:0] wa;
    logic [2:0] ra;
    logic [7:0] lo, hi, junk;
    logic [4:0] e0, e1;

    rst = 1'b1; scl_m = 1'b1; sda_m = 1'b1; sel = 1'b0; run = 1'b0; ext = 1'b0;
    tick(5);
    chk("R1 vid in reset", 32'(vid), 0);
    chk("R1 done in reset", 32'(done), 0);
    chk("R1 oe in reset", 32'(sda_oe), 0);
    rst = 1'b0;
    tick(1);
    chk("R1 vid after reset", 32'(vid), 0);
    chk("R1 done after reset", 32'(done), 0);

    // R2: every 7-bit address
    for (int ad = 0; ad < 128; ad++) begin
      bus_start();
      send_byte({7'(ad), 1'b0}, a);
      bus_stop();
      chk("R2 address ack", 32'(a), 32'(ad == int'(DEV)));
    end

    // R4/R5 read before any setup
    read_word(1'b1, lo, hi, ra);
    chk("R4 read acks", 32'(ra), 32'h7);
    chk("R5 empty low byte", 32'(lo), 32'(exp_byte(5'd0, 1'b0)));
    chk("R5 empty high byte", 32'(hi), 32'(exp_byte(5'd0, 1'b0)));
    chk("R10 done before setup", 32'(done), 0);

    // R11: abort with stop after low byte
    bus_start();
    send_byte({DEV, 1'b0}, a);
    send_byte(SETUP, a);
    send_byte(8'hF8, a);
    bus_stop();
    // R11: abort with repeated start partway through high byte
    bus_start();
    send_byte({DEV, 1'b0}, a);
    send_byte(SETUP, a);
    send_byte(8'hF8, a);
    put_bit(1'b1); put_bit(1'b0);
    bus_start();
    send_byte({DEV, 1'b1}, a);
    recv_byte(lo, 1'b1);
    recv_byte(hi, 1'b0);
    bus_stop();
    chk("R11 aborted low unchanged", 32'(lo), 32'(exp_byte(5'd0, 1'b0)));
    chk("R11 aborted high unchanged", 32'(hi), 32'(exp_byte(5'd0, 1'b0)));
    chk("R11 done after abort", 32'(done), 0);

    // R3/R5/R9/R10: every code value
    for (int c = 0; c < 32; c++) begin
      e0 = 5'(c);
      e1 = 5'(31 - c);
      run = c[0];
      ext = 1'b0;
      write_word(SETUP, {e0, 3'b111}, {e1, 3'b101}, wa);
      chk("R3 setup acks", 32'(wa), 32'hF);
      chk("R10 done after setup", 32'(done), 1);
      sel = 1'b0; tick(2);
      chk("R9 sel low gives code 0", 32'(vid), 32'(e0));
      sel = 1'b1; tick(2);
      chk("R9 sel high gives code 1", 32'(vid), 32'(e1));
      read_word(1'b1, lo, hi, ra);
      chk("R4 low byte", 32'(lo), 32'(exp_byte(e0, run)));
      chk("R5 high byte", 32'(hi), 32'(exp_byte(e1, run)));
      chk("R6 idle after read", 32'(sda_oe), 0);
    end

    // R7: non-setup command leaves codes alone
    run = 1'b0;
    write_word(ONCMD, 8'h11, 8'h22, wa);
    chk("R7 on command acks", 32'(wa), 32'hF);
    read_word(1'b1, lo, hi, ra);
    chk("R7 low unchanged", 32'(lo), 32'(exp_byte(5'd31, 1'b0)));
    chk("R7 high unchanged", 32'(hi), 32'(exp_byte(5'd0, 1'b0)));

    // R8: locked while both enables high
    run = 1'b1; ext = 1'b1;
    write_word(SETUP, 8'h28, 8'h48, wa);
    read_word(1'b1, lo, hi, ra);
    chk("R8 locked low unchanged", 32'(lo), 32'(exp_byte(5'd31, 1'b1)));
    chk("R8 locked high unchanged", 32'(hi), 32'(exp_byte(5'd0, 1'b1)));
    ext = 1'b0;
    write_word(SETUP, 8'h28, 8'h48, wa);
    read_word(1'b1, lo, hi, ra);
    chk("R8 unlocked low written", 32'(lo), 32'(exp_byte(5'd5, 1'b1)));
    chk("R8 unlocked high written", 32'(hi), 32'(exp_byte(5'd9, 1'b1)));

    // R6: master NACKs the low byte, slave must not drive the next byte
    read_word(1'b0, lo, junk, ra);
    chk("R6 low byte before nack", 32'(lo), 32'(exp_byte(5'd5, 1'b1)));
    chk("R6 released after nack", 32'(junk), 32'hFF);
    chk("R12 oe idle at end", 32'(sda_oe), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule